// File: doc/BRIEF.md
# Power-State-Aware Reset Distributor

This block turns a handful of reset causes into nine separate active-low reset outputs for a network interface that sits on a host bus with power-management states. The causes are a raw power-good level, the host bus reset, the device power state, a software reset bit, a PHY reset bit, a PHY soft-reset bit and a wake-from-D3-cold enable. Each output domain has its own set of causes. The host reset is read as a level while the device is in D0 and as a rising edge while it is in D3. A power-state exit from D3 hot to D0 uninitialised produces its own pulse.

A power-on timer holds every domain in reset for a parameterised number of cycles once power is good. The software and PHY reset bits start fixed-length pulses and return a one-cycle done strobe, which the owning register uses to clear the bit. Every output goes low asynchronously and returns high only through a clocked synchroniser. A separate output covers register bits that software reset must not clear.

Top module: `pwr_rst_dist`

## Requirements
- R1: While `pwr_good` is low, every output is low. After `pwr_good` rises, all outputs stay low until the rising clock edge numbered `POR_CYCLES+2`, counting the first edge after the rise as edge 1.
- R2: `pstate` is coded as 0 for D0 uninitialised, 1 for D0 active, 2 for D3 hot and 3 for D3 cold. In states 0 and 1, a low `host_rst_n` holds every host-reset domain in reset for as long as it stays low. Those domains are PHY, EEPROM load, configuration, subsystem ID, MAC, DMA, CSR and no-software-reset bits, plus PME as R8 allows.
- R3: In states 2 and 3, a low `host_rst_n` has no effect. A low-to-high transition starts a host reset pulse of `PULSE_CYCLES` cycles on the same domains as R2.
- R4: When `pstate` changes from 2 to 0, an exit pulse of `PULSE_CYCLES` cycles resets the configuration, MAC, DMA, CSR and no-software-reset domains. It does not reset EEPROM load, subsystem ID or PME.
- R5: A rising edge on `sw_rst_req` resets only the MAC, DMA and CSR domains for `PULSE_CYCLES` cycles. `sw_rst_done` is high for one cycle after the last cycle of the pulse.
- R6: Software reset never lowers `rst_cfg_n`, `rst_ssid_n` or `rst_nasr_n`. The exit pulse never lowers `rst_ssid_n`.
- R7: `rst_eeprom_n` responds only to power-on reset and host reset.
- R8: `rst_pme_n` follows power-on reset always. It follows host reset only while `d3cold_wake_en` is 0.
- R9: A rising edge on `phy_rst_req` resets only the PHY domain for `PULSE_CYCLES` cycles, and `phy_rst_done` is high for one cycle after the pulse. A high `phy_soft_req` holds the PHY in reset as a level.
- R10: The exit pulse resets the PHY only if a PHY reset pulse or PHY soft reset was active in the cycle the state entered D3 hot.
- R11: An output falls as soon as its cause appears. It rises on the second rising clock edge after the cause has gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Raw power-good level, low forces full reset |
| host_rst_n | input | 1 | Active-low host bus reset |
| pstate | input | 2 | Device power state (0 D0 uninit, 1 D0 active, 2 D3 hot, 3 D3 cold) |
| sw_rst_req | input | 1 | Software reset bit |
| phy_rst_req | input | 1 | PHY reset control bit |
| phy_soft_req | input | 1 | PHY soft-reset bit, level |
| d3cold_wake_en | input | 1 | Wake from D3 cold supported |
| sw_rst_done | output | 1 | One-cycle strobe that clears the software reset bit |
| phy_rst_done | output | 1 | One-cycle strobe that clears the PHY reset bit |
| rst_pme_n | output | 1 | PME logic reset |
| rst_phy_n | output | 1 | PHY reset |
| rst_eeprom_n | output | 1 | EEPROM load reset |
| rst_cfg_n | output | 1 | Configuration register reset |
| rst_ssid_n | output | 1 | Subsystem ID register reset |
| rst_mac_n | output | 1 | MAC reset |
| rst_dma_n | output | 1 | DMA engine reset |
| rst_csr_n | output | 1 | Control/status register reset |
| rst_nasr_n | output | 1 | Reset for register bits software reset must spare |

## Verification
The assertions check four things on every cycle:
- the nesting of the domains: subsystem ID inside configuration, configuration inside MAC, and no-software-reset bits inside CSR;
- the level action of the host reset in D0 states;
- the wake-enable exemption of PME;
- the exact length of the power-on count, pulse termination, and the rule that a synchroniser releases only after its request has gone.

Other behaviours are shown only by the bench's scenarios. These are the edge-only reading of the host reset in D3, the exit pulse from D3 hot, the conditional PHY reset on that exit, and the done-strobe timing of the two self-clearing bits.

// File: rtl/prd_pkg.sv
package prd_pkg;

   typedef enum logic [1:0] {
      PS_D0_UNINIT = 2'd0,
      PS_D0_ACTIVE = 2'd1,
      PS_D3_HOT    = 2'd2,
      PS_D3_COLD   = 2'd3
   } pstate_e;

   localparam int DOM_PME   = 0;
   localparam int DOM_PHY   = 1;
   localparam int DOM_EEP   = 2;
   localparam int DOM_CFG   = 3;
   localparam int DOM_SSID  = 4;
   localparam int DOM_MAC   = 5;
   localparam int DOM_DMA   = 6;
   localparam int DOM_CSR   = 7;
   localparam int DOM_NASR  = 8;
   localparam int DOM_COUNT = 9;

   localparam int PG_HOST  = 0;
   localparam int PG_EXIT  = 1;
   localparam int PG_SW    = 2;
   localparam int PG_PHY   = 3;
   localparam int PG_COUNT = 4;

endpackage

// File: rtl/prd_por_timer.sv
module prd_por_timer #(
   parameter int unsigned CYCLES = 2625000
) (
   input  logic clk,
   input  logic pwr_good,
   output logic por_act
);
   localparam int unsigned CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt;
   logic          done;

   if (CYCLES < 2) begin : g_bad_cycles
      $error("prd_por_timer: CYCLES must be at least 2");
   end

   always_ff @(posedge clk or negedge pwr_good) begin
      if (!pwr_good) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (!done) begin
         cnt <= cnt + 1'b1;
         if (cnt == CW'(CYCLES - 1)) done <= 1'b1;
      end
   end

   assign por_act = ~done;

   // R1: the hold ends exactly after the configured count
   p_por_len_r1: assert property (@(posedge clk) disable iff (!pwr_good)
      $rose(done) |-> ($past(cnt) == CW'(CYCLES - 1)));

endmodule

// File: rtl/prd_pulse.sv
module prd_pulse #(
   parameter int unsigned LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic active,
   output logic done
);
   localparam int unsigned CW = (LEN < 2) ? 1 : $clog2(LEN);

   logic [CW-1:0] cnt;

   if (LEN < 1) begin : g_bad_len
      $error("prd_pulse: LEN must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b0;
         done   <= 1'b0;
      end else if (trig) begin
         cnt    <= '0;
         active <= 1'b1;
         done   <= 1'b0;
      end else if (active) begin
         if (cnt == CW'(LEN - 1)) begin
            active <= 1'b0;
            done   <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         done <= 1'b0;
      end
   end

   // R5: the done strobe marks the end of a pulse and nothing else
   p_done_ends_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $fell(active));

endmodule

// File: rtl/prd_rst_sync.sv
module prd_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic req,
   output logic rst_n
);
   logic [STAGES-1:0] sh;

   if (STAGES < 2) begin : g_bad_stages
      $error("prd_rst_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or posedge req) begin
      if (req) sh <= '0;
      else     sh <= {sh[STAGES-2:0], 1'b1};
   end

   assign rst_n = sh[STAGES-1];

   // R11: release only after the request was already gone at the prior edge
   p_sync_release_r11: assert property (@(posedge clk) disable iff (req)
      $rose(rst_n) |-> !$past(req));

endmodule

// File: rtl/pwr_rst_dist.sv
module pwr_rst_dist
   import prd_pkg::*;
#(
   parameter int unsigned POR_CYCLES   = 2625000,
   parameter int unsigned PULSE_CYCLES = 16,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       pwr_good,
   input  logic       host_rst_n,
   input  logic [1:0] pstate,
   input  logic       sw_rst_req,
   input  logic       phy_rst_req,
   input  logic       phy_soft_req,
   input  logic       d3cold_wake_en,
   output logic       sw_rst_done,
   output logic       phy_rst_done,
   output logic       rst_pme_n,
   output logic       rst_phy_n,
   output logic       rst_eeprom_n,
   output logic       rst_cfg_n,
   output logic       rst_ssid_n,
   output logic       rst_mac_n,
   output logic       rst_dma_n,
   output logic       rst_csr_n,
   output logic       rst_nasr_n
);

   if (PULSE_CYCLES < 1) begin : g_bad_pulse
      $error("pwr_rst_dist: PULSE_CYCLES must be at least 1");
   end

   logic                 por_act;
   pstate_e              ps, ps_q;
   logic                 hr_s1, hr_s2, hr_q;
   logic                 sw_q, phy_q;
   logic                 phy_d3_flag;
   logic                 host_lvl, host_any, exit_any, d3hot_entry;
   logic [PG_COUNT-1:0]  pg_trig, pg_act, pg_done;
   logic [DOM_COUNT-1:0] dom_req, dom_rst_n;

   prd_por_timer #(.CYCLES(POR_CYCLES)) u_por (
      .clk      (clk),
      .pwr_good (pwr_good),
      .por_act  (por_act)
   );

   assign ps = pstate_e'(pstate);

   // host reset as a level only while in a D0 state
   assign host_lvl    = ~pstate[1] & ~host_rst_n;
   assign d3hot_entry = (ps == PS_D3_HOT) && (ps_q != PS_D3_HOT);

   always_ff @(posedge clk or negedge pwr_good) begin
      if (!pwr_good) begin
         hr_s1       <= 1'b1;
         hr_s2       <= 1'b1;
         hr_q        <= 1'b1;
         sw_q        <= 1'b0;
         phy_q       <= 1'b0;
         ps_q        <= PS_D0_UNINIT;
         phy_d3_flag <= 1'b0;
      end else begin
         hr_s1 <= host_rst_n;
         hr_s2 <= hr_s1;
         hr_q  <= hr_s2;
         sw_q  <= sw_rst_req;
         phy_q <= phy_rst_req;
         ps_q  <= ps;
         if (d3hot_entry) phy_d3_flag <= pg_act[PG_PHY] | phy_soft_req;
      end
   end

   always_comb begin
      pg_trig          = '0;
      pg_trig[PG_HOST] = pstate[1] & hr_s2 & ~hr_q;
      pg_trig[PG_EXIT] = (ps_q == PS_D3_HOT) && (ps == PS_D0_UNINIT);
      pg_trig[PG_SW]   = sw_rst_req & ~sw_q;
      pg_trig[PG_PHY]  = phy_rst_req & ~phy_q;
   end

   for (genvar g = 0; g < PG_COUNT; g++) begin : g_pulse
      prd_pulse #(.LEN(PULSE_CYCLES)) u_pulse (
         .clk    (clk),
         .rst_n  (pwr_good),
         .trig   (pg_trig[g]),
         .active (pg_act[g]),
         .done   (pg_done[g])
      );
   end

   assign host_any = host_lvl | pg_act[PG_HOST];
   assign exit_any = pg_act[PG_EXIT];

   always_comb begin
      dom_req            = '0;
      dom_req[DOM_PME]   = por_act | (host_any & ~d3cold_wake_en);
      dom_req[DOM_PHY]   = por_act | host_any | pg_act[PG_PHY] | phy_soft_req
                           | (exit_any & phy_d3_flag);
      dom_req[DOM_EEP]   = por_act | host_any;
      dom_req[DOM_SSID]  = por_act | host_any;
      dom_req[DOM_CFG]   = por_act | host_any | exit_any;
      dom_req[DOM_NASR]  = por_act | host_any | exit_any;
      dom_req[DOM_MAC]   = por_act | host_any | exit_any | pg_act[PG_SW];
      dom_req[DOM_DMA]   = por_act | host_any | exit_any | pg_act[PG_SW];
      dom_req[DOM_CSR]   = por_act | host_any | exit_any | pg_act[PG_SW];
   end

   for (genvar d = 0; d < DOM_COUNT; d++) begin : g_sync
      prd_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .req   (dom_req[d]),
         .rst_n (dom_rst_n[d])
      );
   end

   assign rst_pme_n    = dom_rst_n[DOM_PME];
   assign rst_phy_n    = dom_rst_n[DOM_PHY];
   assign rst_eeprom_n = dom_rst_n[DOM_EEP];
   assign rst_cfg_n    = dom_rst_n[DOM_CFG];
   assign rst_ssid_n   = dom_rst_n[DOM_SSID];
   assign rst_mac_n    = dom_rst_n[DOM_MAC];
   assign rst_dma_n    = dom_rst_n[DOM_DMA];
   assign rst_csr_n    = dom_rst_n[DOM_CSR];
   assign rst_nasr_n   = dom_rst_n[DOM_NASR];

   assign sw_rst_done  = pg_done[PG_SW];
   assign phy_rst_done = pg_done[PG_PHY];

   // R2: host reset low in a D0 state holds the host domains
   p_host_level_r2: assert property (@(posedge clk) disable iff (!pwr_good)
      (!pstate[1] && !host_rst_n) |-> (!rst_eeprom_n && !rst_mac_n && !rst_phy_n));

   // R6: domain nesting, subsystem ID within configuration within MAC
   p_ssid_in_cfg_r6: assert property (@(posedge clk) disable iff (!pwr_good)
      !rst_ssid_n |-> !rst_cfg_n);
   p_cfg_in_mac_r6: assert property (@(posedge clk) disable iff (!pwr_good)
      !rst_cfg_n |-> !rst_mac_n);
   p_nasr_in_csr_r6: assert property (@(posedge clk) disable iff (!pwr_good)
      !rst_nasr_n |-> !rst_csr_n);

   // R8: PME escapes a host reset only while D3-cold wake is enabled
   p_pme_exempt_r8: assert property (@(posedge clk) disable iff (!pwr_good)
      (!rst_eeprom_n && rst_pme_n) |->
         (d3cold_wake_en || $past(d3cold_wake_en) || $past(d3cold_wake_en, 2)));

   // R11: domains stay held through the synchroniser after a pulse ends
   p_host_hold_r11: assert property (@(posedge clk) disable iff (!pwr_good)
      pg_done[PG_HOST] |-> !rst_eeprom_n);
   p_exit_hold_r11: assert property (@(posedge clk) disable iff (!pwr_good)
      pg_done[PG_EXIT] |-> !rst_cfg_n);

endmodule

// File: tb/tb_pwr_rst_dist.sv
`timescale 1ns/1ps
module tb_pwr_rst_dist;
   localparam int POR   = 20;
   localparam int PULSE = 4;

   logic clk = 1'b0;
   logic pwr_good = 1'b0, host_rst_n = 1'b1;
   logic [1:0] pstate = 2'd0;
   logic sw_rst_req = 1'b0, phy_rst_req = 1'b0, phy_soft_req = 1'b0, d3cold_wake_en = 1'b0;
   logic sw_rst_done, phy_rst_done;
   logic rst_pme_n, rst_phy_n, rst_eeprom_n, rst_cfg_n, rst_ssid_n;
   logic rst_mac_n, rst_dma_n, rst_csr_n, rst_nasr_n;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   pwr_rst_dist #(.POR_CYCLES(POR), .PULSE_CYCLES(PULSE), .SYNC_STAGES(2)) dut (
      .clk, .pwr_good, .host_rst_n, .pstate, .sw_rst_req, .phy_rst_req,
      .phy_soft_req, .d3cold_wake_en, .sw_rst_done, .phy_rst_done,
      .rst_pme_n, .rst_phy_n, .rst_eeprom_n, .rst_cfg_n, .rst_ssid_n,
      .rst_mac_n, .rst_dma_n, .rst_csr_n, .rst_nasr_n
   );

   // bit order: 0 pme, 1 phy, 2 eeprom, 3 cfg, 4 ssid, 5 mac, 6 dma, 7 csr, 8 nasr
   wire [8:0] held = ~{rst_nasr_n, rst_csr_n, rst_dma_n, rst_mac_n, rst_ssid_n,
                       rst_cfg_n, rst_eeprom_n, rst_phy_n, rst_pme_n};

   function automatic logic [8:0] expect_v(bit por, bit host, bit ex, bit sw,
                                           bit phy, bit wake, bit flag);
      logic [8:0] v;
      v[0] = por | (host & ~wake);
      v[1] = por | host | phy | (ex & flag);
      v[2] = por | host;
      v[3] = por | host | ex;
      v[4] = por | host;
      v[5] = por | host | ex | sw;
      v[6] = v[5];
      v[7] = v[5];
      v[8] = por | host | ex;
      return v;
   endfunction

   task automatic tick(input int n);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic chk(input string tag, input logic [8:0] e);
      checks++;
      if (held !== e) begin
         errors++;
         $display("FAIL %s held=%b expected=%b", tag, held, e);
      end
   endtask

   task automatic chk_int(input string tag, input int got, input int e);
      checks++;
      if (got != e) begin
         errors++;
         $display("FAIL %s got=%0d expected=%0d", tag, got, e);
      end
   endtask

   task automatic set_ps(input logic [1:0] p);
      pstate = p;
      tick(12);
   endtask

   initial begin
      int n;
      bit seen;
      @(negedge clk);
      tick(3);
      chk("R1 all held while power bad", 9'h1FF);

      // R1: exact power-on hold length
      pwr_good = 1'b1;
      for (int k = 1; k <= POR + 3; k++) begin
         tick(1);
         chk("R1 por release edge", (k >= POR + 2) ? 9'h000 : 9'h1FF);
      end

      // R2 R3 R7 R8: host reset over every state and wake setting
      for (int w = 0; w < 2; w++) begin
         d3cold_wake_en = w[0];
         for (int p = 0; p < 4; p++) begin
            set_ps(p[1:0]);
            chk("R2 idle before host reset", 9'h000);
            host_rst_n = 1'b0;
            tick(2);
            chk(p < 2 ? "R2 level reset in D0" : "R3 low ignored in D3",
                expect_v(0, p < 2, 0, 0, 0, w[0], 0));
            tick(4);
            chk(p < 2 ? "R8 level held in D0" : "R3 low still ignored",
                expect_v(0, p < 2, 0, 0, 0, w[0], 0));
            host_rst_n = 1'b1;
            tick(4);
            chk(p < 2 ? "R11 level released" : "R3 rising edge pulse R7",
                expect_v(0, p >= 2, 0, 0, 0, w[0], 0));
            tick(12);
            chk("R3 settled after host reset", 9'h000);
         end
      end
      d3cold_wake_en = 1'b0;

      // R4: exit from D3 hot, PHY not reset on entry
      set_ps(2'd1);
      set_ps(2'd2);
      pstate = 2'd0;
      tick(2);
      chk("R4 exit pulse without PHY flag", expect_v(0, 0, 1, 0, 0, 0, 0));
      tick(12);
      chk("R4 settled after exit", 9'h000);

      // R10: PHY reset active on entry, so exit resets PHY too
      set_ps(2'd1);
      phy_rst_req = 1'b1;
      tick(1);
      pstate = 2'd2;
      seen = 0;
      for (int i = 0; i < 40 && !seen; i++) begin
         tick(1);
         if (phy_rst_done) seen = 1;
      end
      phy_rst_req = 1'b0;
      tick(12);
      chk("R10 idle in D3 hot", 9'h000);
      pstate = 2'd0;
      tick(2);
      chk("R10 exit resets PHY after flagged entry", expect_v(0, 0, 1, 0, 0, 0, 1));
      tick(12);
      chk("R10 settled", 9'h000);

      // R5 R6: software reset pulse and done timing
      sw_rst_req = 1'b1;
      n = 0;
      seen = 0;
      for (int i = 0; i < 40 && !seen; i++) begin
         tick(1);
         n++;
         if (n == 2) chk("R5 R6 software reset domains", expect_v(0, 0, 0, 1, 0, 0, 0));
         if (sw_rst_done) seen = 1;
      end
      chk_int("R5 sw done edge count", n, PULSE + 1);
      sw_rst_req = 1'b0;
      tick(3);
      chk("R5 released after software reset", 9'h000);

      // R9: PHY reset bit pulse and done timing
      phy_rst_req = 1'b1;
      n = 0;
      seen = 0;
      for (int i = 0; i < 40 && !seen; i++) begin
         tick(1);
         n++;
         if (n == 2) chk("R9 PHY bit resets only PHY", expect_v(0, 0, 0, 0, 1, 0, 0));
         if (phy_rst_done) seen = 1;
      end
      chk_int("R9 phy done edge count", n, PULSE + 1);
      phy_rst_req = 1'b0;
      tick(3);
      chk("R9 released after PHY pulse", 9'h000);

      // R9 R11: PHY soft reset level and synchronous release
      phy_soft_req = 1'b1;
      #1;
      chk("R11 PHY soft reset asserts at once", expect_v(0, 0, 0, 0, 1, 0, 0));
      tick(3);
      chk("R9 PHY soft reset held", expect_v(0, 0, 0, 0, 1, 0, 0));
      phy_soft_req = 1'b0;
      tick(1);
      chk("R11 PHY held one edge after release", expect_v(0, 0, 0, 0, 1, 0, 0));
      tick(1);
      chk("R11 PHY released on second edge", 9'h000);

      // R1 R11: power loss resets everything asynchronously
      pwr_good = 1'b0;
      #1;
      chk("R11 power loss asserts at once", 9'h1FF);
      tick(2);
      pwr_good = 1'b1;
      tick(POR + 1);
      chk("R1 still held one edge early", 9'h1FF);
      tick(1);
      chk("R1 released after repower", 9'h000);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired got=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule